// File: doc/BRIEF.md
# Parallel I/O Pin Bank Controller

This block owns one bank of I/O pins (32 by default). For every pin it decides whether the pad is driven by general-purpose output state held in the block, or by one of four peripheral functions. It also produces the per-pin pad controls: pull-up, pull-down, input filter enable, Schmitt-trigger disable and open-drain style multi-drive. A simple word-addressed register bus sets the state. Most per-pin controls are reached through separate set and clear addresses. Software can therefore change any group of pins with one write and no read-modify-write.

The peripheral choice for a pin is coded across two plain read/write select registers, one bit per pin in each. The pad input levels pass through a synchronizer and can be read back. The bus has no handshake. A write takes effect at the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `pio_bank_ctrl`

## Requirements
- R1: After reset every pin is GPIO-owned, output disabled, output data 0, pull-up on, pull-down off, multi-drive off, filter off, interrupt mask 0, both select registers 0 and Schmitt disable 0.
- R2: Each set/clear pair works as follows: a 1 in the written word sets (set address) or clears (clear address) the bit of that pin, and a 0 leaves it unchanged. The status address returns the current state, and set and clear addresses read 0. The word addresses are: ownership 0/1/2, output enable 3/4/5, output data 6/7/8, pull-up 9/10/11, pull-down 12/13/14, multi-drive 15/16/17, filter 18/19/20 (set/clear/status).
- R3: Setting pull-down on a pin clears its pull-up, and setting pull-up clears its pull-down. `pad_pu` and `pad_pd` are never both 1 on one pin.
- R4: A pin whose ownership bit is 0 takes its pad value and enable from peripheral k. Here k is coded as {select-high bit, select-low bit}: A=00, B=01 (low=1), C=10 (high=1), D=11. Peripheral k's pin i is bit k*N_PINS+i of `per_out` and `per_oe`.
- R5: A pin whose ownership bit is 1 drives its output data bit onto `pad_out`, with `pad_oe` equal to its output enable bit. The data can therefore be written before the enable.
- R6: With multi-drive set on a pin, `pad_out` is 0 and `pad_oe` is 1 only while the selected source drives low with its enable high.
- R7: Select-low (address 24), select-high (25) and Schmitt disable (26) are read/write registers. Schmitt disable appears on `pad_schmitt_dis`, and filter state appears on `pad_filt_en`.
- R8: Address 27 returns `pad_in` delayed through SYNC_STAGES flops (2 by default).
- R9: Interrupt mask enable (21) sets and disable (22) clears bits of the mask. The mask reads at 23 and drives `pin_irq_en`.
- R10: Unmapped addresses (28 to 31) read 0. A write to a status or read-only address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | N_PINS | Write data, bit n for pin n |
| bus_rdata | output | N_PINS | Read data for bus_addr |
| per_out | input | 4*N_PINS | Peripheral output values, peripheral k at slice k |
| per_oe | input | 4*N_PINS | Peripheral output enables, peripheral k at slice k |
| pad_in | input | N_PINS | Asynchronous pad input levels |
| pad_out | output | N_PINS | Pad output value |
| pad_oe | output | N_PINS | Pad output enable |
| pad_pu | output | N_PINS | Pull-up enable |
| pad_pd | output | N_PINS | Pull-down enable |
| pad_filt_en | output | N_PINS | Input filter enable |
| pad_schmitt_dis | output | N_PINS | Schmitt-trigger disable |
| pin_irq_en | output | N_PINS | Per-pin interrupt mask |

## Verification
The assertions assume one access per cycle: a single `bus_wr` addresses exactly one register, so a set and a clear of the same control can never land in the same cycle. They also assume `bus_wdata` is known whenever `bus_wr` is high. The stimulus drives all bus inputs on the falling edge and never leaves `bus_wr` high across two writes with undefined data. Random writes draw addresses from the whole 5-bit space, unmapped ones included, so the pull exclusivity and no-effect checks see every address. Pad and peripheral inputs change only on the falling edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int ADDR_W = 5;
   localparam int NUM_PERIPH = 4;

   localparam logic [ADDR_W-1:0] A_OWN_SET  = 5'd0;
   localparam logic [ADDR_W-1:0] A_OWN_CLR  = 5'd1;
   localparam logic [ADDR_W-1:0] A_OWN_STA  = 5'd2;
   localparam logic [ADDR_W-1:0] A_OE_SET   = 5'd3;
   localparam logic [ADDR_W-1:0] A_OE_CLR   = 5'd4;
   localparam logic [ADDR_W-1:0] A_OE_STA   = 5'd5;
   localparam logic [ADDR_W-1:0] A_DAT_SET  = 5'd6;
   localparam logic [ADDR_W-1:0] A_DAT_CLR  = 5'd7;
   localparam logic [ADDR_W-1:0] A_DAT_STA  = 5'd8;
   localparam logic [ADDR_W-1:0] A_PU_SET   = 5'd9;
   localparam logic [ADDR_W-1:0] A_PU_CLR   = 5'd10;
   localparam logic [ADDR_W-1:0] A_PU_STA   = 5'd11;
   localparam logic [ADDR_W-1:0] A_PD_SET   = 5'd12;
   localparam logic [ADDR_W-1:0] A_PD_CLR   = 5'd13;
   localparam logic [ADDR_W-1:0] A_PD_STA   = 5'd14;
   localparam logic [ADDR_W-1:0] A_MD_SET   = 5'd15;
   localparam logic [ADDR_W-1:0] A_MD_CLR   = 5'd16;
   localparam logic [ADDR_W-1:0] A_MD_STA   = 5'd17;
   localparam logic [ADDR_W-1:0] A_FLT_SET  = 5'd18;
   localparam logic [ADDR_W-1:0] A_FLT_CLR  = 5'd19;
   localparam logic [ADDR_W-1:0] A_FLT_STA  = 5'd20;
   localparam logic [ADDR_W-1:0] A_IRQ_SET  = 5'd21;
   localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 5'd22;
   localparam logic [ADDR_W-1:0] A_IRQ_STA  = 5'd23;
   localparam logic [ADDR_W-1:0] A_SEL_LO   = 5'd24;
   localparam logic [ADDR_W-1:0] A_SEL_HI   = 5'd25;
   localparam logic [ADDR_W-1:0] A_SCHM     = 5'd26;
   localparam logic [ADDR_W-1:0] A_LEVEL    = 5'd27;

   // peripheral code is {select-high, select-low}
   typedef enum logic [1:0] {
      PSEL_A = 2'b00,
      PSEL_B = 2'b01,
      PSEL_C = 2'b10,
      PSEL_D = 2'b11
   } psel_e;
endpackage

// File: rtl/pio_w1sc_reg.sv
module pio_w1sc_reg #(
   parameter int          W       = 32,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] force_clr,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m, clr_m;

   initial begin
      if (W < 1) $error("pio_w1sc_reg: W must be at least 1");
   end

   assign set_m = set_we ? wdata : '0;
   assign clr_m = (clr_we ? wdata : '0) | force_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= (q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 0 || STAGES > 4) $error("pio_in_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
   parameter int N = 32
) (
   input  logic [N-1:0]   gpio_own,
   input  logic [N-1:0]   gpio_dat,
   input  logic [N-1:0]   gpio_oe,
   input  logic [N-1:0]   sel_lo,
   input  logic [N-1:0]   sel_hi,
   input  logic [N-1:0]   multi_drv,
   input  logic [4*N-1:0] per_out,
   input  logic [4*N-1:0] per_oe,
   output logic [N-1:0]   pad_out,
   output logic [N-1:0]   pad_oe
);
   import pio_pkg::*;

   generate
      for (genvar i = 0; i < N; i++) begin : g_pin
         psel_e code;
         logic  src_val, src_en;
         assign code = psel_e'({sel_hi[i], sel_lo[i]});
         always_comb begin
            if (gpio_own[i]) begin
               src_val = gpio_dat[i];
               src_en  = gpio_oe[i];
            end else begin
               src_val = per_out[int'(code)*N + i];
               src_en  = per_oe[int'(code)*N + i];
            end
         end
         assign pad_out[i] = multi_drv[i] ? 1'b0 : src_val;
         assign pad_oe[i]  = multi_drv[i] ? (src_en & ~src_val) : src_en;
      end
   endgenerate
endmodule

// File: rtl/pio_bank_ctrl.sv
module pio_bank_ctrl #(
   parameter int N_PINS      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [4:0]            bus_addr,
   input  logic [N_PINS-1:0]     bus_wdata,
   output logic [N_PINS-1:0]     bus_rdata,
   input  logic [4*N_PINS-1:0]   per_out,
   input  logic [4*N_PINS-1:0]   per_oe,
   input  logic [N_PINS-1:0]     pad_in,
   output logic [N_PINS-1:0]     pad_out,
   output logic [N_PINS-1:0]     pad_oe,
   output logic [N_PINS-1:0]     pad_pu,
   output logic [N_PINS-1:0]     pad_pd,
   output logic [N_PINS-1:0]     pad_filt_en,
   output logic [N_PINS-1:0]     pad_schmitt_dis,
   output logic [N_PINS-1:0]     pin_irq_en
);
   import pio_pkg::*;

   localparam logic [N_PINS-1:0] ALL1 = {N_PINS{1'b1}};
   localparam logic [N_PINS-1:0] ALL0 = '0;

   initial begin
      if (N_PINS < 1 || N_PINS > 32) $error("pio_bank_ctrl: N_PINS must be 1..32");
   end

   function automatic logic hit(input logic [4:0] a);
      return bus_wr && (bus_addr == a);
   endfunction

   logic [N_PINS-1:0] own_q, oe_q, dat_q, pu_q, pd_q, md_q, flt_q, irq_q;
   logic [N_PINS-1:0] sel_lo_q, sel_hi_q, schm_q, level;
   logic [N_PINS-1:0] pu_kill, pd_kill;

   // a pull set on a pin knocks out the opposite pull
   assign pu_kill = hit(A_PD_SET) ? bus_wdata : ALL0;
   assign pd_kill = hit(A_PU_SET) ? bus_wdata : ALL0;

   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL1)) u_own (
      .clk, .rst_n, .set_we(hit(A_OWN_SET)), .clr_we(hit(A_OWN_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(own_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_oe (
      .clk, .rst_n, .set_we(hit(A_OE_SET)), .clr_we(hit(A_OE_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(oe_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_dat (
      .clk, .rst_n, .set_we(hit(A_DAT_SET)), .clr_we(hit(A_DAT_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(dat_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL1)) u_pu (
      .clk, .rst_n, .set_we(hit(A_PU_SET)), .clr_we(hit(A_PU_CLR)),
      .wdata(bus_wdata), .force_clr(pu_kill), .q(pu_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_pd (
      .clk, .rst_n, .set_we(hit(A_PD_SET)), .clr_we(hit(A_PD_CLR)),
      .wdata(bus_wdata), .force_clr(pd_kill), .q(pd_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_md (
      .clk, .rst_n, .set_we(hit(A_MD_SET)), .clr_we(hit(A_MD_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(md_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_flt (
      .clk, .rst_n, .set_we(hit(A_FLT_SET)), .clr_we(hit(A_FLT_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(flt_q));
   pio_w1sc_reg #(.W(N_PINS), .RST_VAL(ALL0)) u_irq (
      .clk, .rst_n, .set_we(hit(A_IRQ_SET)), .clr_we(hit(A_IRQ_CLR)),
      .wdata(bus_wdata), .force_clr(ALL0), .q(irq_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_lo_q <= '0;
         sel_hi_q <= '0;
         schm_q   <= '0;
      end else begin
         if (hit(A_SEL_LO)) sel_lo_q <= bus_wdata;
         if (hit(A_SEL_HI)) sel_hi_q <= bus_wdata;
         if (hit(A_SCHM))   schm_q   <= bus_wdata;
      end
   end

   pio_in_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .d(pad_in), .q(level));

   pio_pad_mux #(.N(N_PINS)) u_mux (
      .gpio_own(own_q), .gpio_dat(dat_q), .gpio_oe(oe_q),
      .sel_lo(sel_lo_q), .sel_hi(sel_hi_q), .multi_drv(md_q),
      .per_out, .per_oe, .pad_out, .pad_oe);

   always_comb begin
      unique case (bus_addr)
         A_OWN_STA: bus_rdata = own_q;
         A_OE_STA:  bus_rdata = oe_q;
         A_DAT_STA: bus_rdata = dat_q;
         A_PU_STA:  bus_rdata = pu_q;
         A_PD_STA:  bus_rdata = pd_q;
         A_MD_STA:  bus_rdata = md_q;
         A_FLT_STA: bus_rdata = flt_q;
         A_IRQ_STA: bus_rdata = irq_q;
         A_SEL_LO:  bus_rdata = sel_lo_q;
         A_SEL_HI:  bus_rdata = sel_hi_q;
         A_SCHM:    bus_rdata = schm_q;
         A_LEVEL:   bus_rdata = level;
         default:   bus_rdata = '0;
      endcase
   end

   assign pad_pu          = pu_q;
   assign pad_pd          = pd_q;
   assign pad_filt_en     = flt_q;
   assign pad_schmitt_dis = schm_q;
   assign pin_irq_en      = irq_q;
endmodule

// File: rtl/pio_bank_ctrl_chk.sv
module pio_bank_ctrl_chk #(
   parameter int N = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         bus_wr,
   input logic [4:0]   bus_addr,
   input logic [N-1:0] bus_wdata,
   input logic [N-1:0] pad_out,
   input logic [N-1:0] pad_oe,
   input logic [N-1:0] pad_pu,
   input logic [N-1:0] pad_pd,
   input logic [N-1:0] own_q,
   input logic [N-1:0] oe_q,
   input logic [N-1:0] md_q,
   input logic [N-1:0] sel_lo_q
);
   AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_pd) == '0);                                          // R3
   AST_PU_SET_DROPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'd9) |=> ((pad_pd & $past(bus_wdata)) == '0)); // R3
   AST_OWN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'd0) |=> ((own_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
   AST_OE_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 5'd4) |=> ((oe_q & $past(bus_wdata)) == '0)); // R2
   AST_MD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (md_q & pad_oe & pad_out) == '0);                                  // R6
   AST_SEL_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(sel_lo_q));                                    // R7
endmodule

bind pio_bank_ctrl pio_bank_ctrl_chk #(.N(N_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
   .pad_pu(pad_pu), .pad_pd(pad_pd), .own_q(own_q), .oe_q(oe_q),
   .md_q(md_q), .sel_lo_q(sel_lo_q));

// File: tb/pio_bank_ctrl_tb_top.sv
module pio_bank_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int N = 32;

   logic           clk = 0, rst_n = 0, bus_wr = 0;
   logic [4:0]     bus_addr = '0;
   logic [N-1:0]   bus_wdata = '0, bus_rdata, pad_in = '0;
   logic [4*N-1:0] per_out = '0, per_oe = '0;
   logic [N-1:0]   pad_out, pad_oe, pad_pu, pad_pd, pad_filt_en, pad_schmitt_dis, pin_irq_en;

   int checks = 0, failures = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pio_bank_ctrl #(.N_PINS(N), .SYNC_STAGES(2)) dut_i (.*);

   // ---------------- reference model ----------------
   logic [N-1:0] m_reg [0:31];      // indexed by status/rw address
   logic [N-1:0] in_q [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < 32; a++) m_reg[a] = '0;
         m_reg[2]  = '1;  // ownership
         m_reg[11] = '1;  // pull-up
         in_q.delete();
      end else begin
         in_q.push_back(pad_in);
         if (in_q.size() > 2) void'(in_q.pop_front());
         if (bus_wr) begin
            int a;
            a = bus_addr;
            if (a <= 22 && (a % 3) != 2) begin
               int st;
               st = a - (a % 3) + 2;
               if (a % 3 == 0) m_reg[st] = m_reg[st] | bus_wdata;
               else            m_reg[st] = m_reg[st] & ~bus_wdata;
               if (a == 9)  m_reg[14] = m_reg[14] & ~bus_wdata;
               if (a == 12) m_reg[11] = m_reg[11] & ~bus_wdata;
            end else if (a >= 24 && a <= 26) begin
               m_reg[a] = bus_wdata;
            end
         end
      end
   end

   function automatic logic [N-1:0] exp_rd(input int a);
      if (a == 27) return (in_q.size() == 2) ? in_q[0] : '0;
      if ((a <= 23 && a % 3 == 2) || (a >= 24 && a <= 26)) return m_reg[a];
      return '0;
   endfunction

   task automatic exp_pad(output logic [N-1:0] o, output logic [N-1:0] e);
      for (int i = 0; i < N; i++) begin
         logic v, en;
         int k;
         if (m_reg[2][i]) begin v = m_reg[8][i]; en = m_reg[5][i]; end
         else begin
            k = 2*m_reg[25][i] + m_reg[24][i];
            v = per_out[k*N+i]; en = per_oe[k*N+i];
         end
         if (m_reg[17][i]) begin o[i] = 1'b0; e[i] = en & ~v; end
         else begin o[i] = v; e[i] = en; end
      end
   endtask

   task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
      end
   endtask

   // per-clock comparison against the model
   always @(posedge clk) begin
      #(CLK_PERIOD/4);
      if (rst_n && !done) begin
         logic [N-1:0] eo, ee;
         exp_pad(eo, ee);
         chk("R5 pad_out", pad_out, eo);
         chk("R5 pad_oe", pad_oe, ee);
         chk("R3 pad_pu", pad_pu, m_reg[11]);
         chk("R3 pad_pd", pad_pd, m_reg[14]);
         chk("R7 filt", pad_filt_en, m_reg[20]);
         chk("R7 schmitt", pad_schmitt_dis, m_reg[26]);
         chk("R9 irq", pin_irq_en, m_reg[23]);
         chk("R2 rdata", bus_rdata, exp_rd(int'(bus_addr)));
      end
   end

   // ---------------- stimulus ----------------
   task automatic wr(input int a, input logic [N-1:0] d);
      @(negedge clk);
      bus_wr = 1; bus_addr = a[4:0]; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input int a, output logic [N-1:0] d);
      @(negedge clk);
      bus_wr = 0; bus_addr = a[4:0];
      #1 d = bus_rdata;
   endtask

   initial begin
      logic [N-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      rd(2, r);  chk("R1 own", r, '1);
      rd(11, r); chk("R1 pu", r, '1);
      rd(14, r); chk("R1 pd", r, '0);
      rd(5, r);  chk("R1 oe", r, '0);
      rd(24, r); chk("R1 sel_lo", r, '0);
      chk("R1 pad_oe", pad_oe, '0);
      // R5 data first, then enable
      wr(6, 32'h0000_00F0);
      chk("R5 no drive before enable", pad_oe, '0);
      wr(3, 32'h0000_00FF);
      chk("R5 pad_out", pad_out, 32'h0000_00F0);
      chk("R5 pad_oe", pad_oe, 32'h0000_00FF);
      // R2 zero bits no effect, clear register reads 0
      wr(4, 32'h0000_0000);
      rd(5, r); chk("R2 zero clr no effect", r, 32'h0000_00FF);
      rd(4, r); chk("R2 clr addr reads 0", r, '0);
      wr(4, 32'h0000_000F);
      rd(5, r); chk("R2 clr bits", r, 32'h0000_00F0);
      // R4 pins 0..3 to peripherals A..D
      per_oe  = '1;
      per_out = {32'h0000_0008, 32'h0000_0004, 32'h0000_0002, 32'h0000_0001};
      wr(1, 32'h0000_000F);
      wr(24, 32'h0000_000A);
      wr(25, 32'h0000_000C);
      chk("R4 select A..D high", pad_out[3:0], 32'h0000_000F);
      per_out = ~per_out;
      @(negedge clk);
      chk("R4 select A..D low", pad_out[3:0], '0);
      chk("R4 enables", pad_oe[3:0], 32'h0000_000F);
      // R6 multi-drive
      wr(15, 32'h0000_00F3);
      chk("R6 never drive high", pad_out & 32'h0000_00F3, '0);
      chk("R6 drive low only", pad_oe[7:4], '0);
      chk("R6 periph low drives", pad_oe[1:0], 32'h3);
      // R3 pulls
      wr(12, 32'h0000_FF00);
      rd(11, r); chk("R3 pd clears pu", r, 32'hFFFF_00FF);
      wr(9, 32'h0000_0F00);
      rd(14, r); chk("R3 pu clears pd", r, 32'h0000_F000);
      // R7 schmitt and filter
      wr(26, 32'h1234_5678);
      chk("R7 schmitt pin", pad_schmitt_dis, 32'h1234_5678);
      wr(18, 32'h0000_0101);
      chk("R7 filter pin", pad_filt_en, 32'h0000_0101);
      // R9 interrupt mask
      wr(21, 32'hFF00_00FF);
      wr(22, 32'h0F00_000F);
      chk("R9 irq mask", pin_irq_en, 32'hF000_00F0);
      // R8 pin level
      @(negedge clk); pad_in = 32'hA5A5_5A5A;
      repeat (3) @(negedge clk);
      rd(27, r); chk("R8 level", r, 32'hA5A5_5A5A);
      // R10 unmapped and read-only writes
      wr(27, 32'hFFFF_FFFF);
      wr(2, 32'h0);
      rd(2, r);  chk("R10 status write ignored", r, 32'hFFFF_FFF0);
      rd(30, r); chk("R10 unmapped reads 0", r, '0);
      // random traffic compared every clock
      for (int n = 0; n < 600; n++) begin
         if (n % 16 == 0) begin
            per_out = {$urandom, $urandom, $urandom, $urandom};
            per_oe  = {$urandom, $urandom, $urandom, $urandom};
            pad_in  = $urandom;
         end
         wr(int'($urandom_range(0, 31)), $urandom);
      end
      repeat (2) @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule